// File: doc/BRIEF.md
# DMA channel control register file

This block is the memory-mapped register front end of a small memory-to-memory DMA controller with several channels. A single-cycle bus request (valid, write, width, address, write data) picks a channel from the address bits above the low twelve and a register from the low twelve bits. Each channel holds a control word, a programmable pending descriptor (configuration, byte count, destination, source) and a read-only running copy of that descriptor. The running copy is loaded from the pending one at the moment a transfer is launched.

Software must own (claim) a channel before it can launch a transfer. Taking ownership loads the pending descriptor with safe defaults. Ownership cannot be given up while a transfer runs. A permitted launch sends a one-cycle start pulse to an external transfer engine, and the running descriptor is presented to that engine. The engine's completion and fault pulses update the status bits. Each channel drives a completion interrupt and a fault interrupt, each gated by its own enable bit.

Read data is registered and appears in the cycle after the read request.

Top module: `dmareg_top`

## Requirements
- R1: Control word bit positions are: bit 0 claim, bit 1 run, bit 14 done interrupt enable, bit 15 error interrupt enable, bit 30 done status, bit 31 error status. All other control bits read as zero. Read data appears on `bus_rdata` in the cycle after the request.
- R2: A control write that takes claim from 0 to 1 clears the pending byte count, destination and source to zero. The same write sets the pending config (offset 0x004) to 0x6600_0000, which is read size field [31:28] = 6, write size field [27:24] = 6, and every other bit zero.
- R3: The running copies (config 0x104, bytes 0x108, destination 0x110, source 0x118) ignore bus writes. They change only when a transfer is launched, and then they take the pending values.
- R4: A control write with claim = 0 while run is set leaves claim set.
- R5: If the channel was unclaimed before a control write, or if the write clears claim while run was low, run is stored as 0 and no start pulse is issued.
- R6: A permitted control write that sets run while run was clear produces `eng_start[k]` high for exactly the following cycle. It also clears done and error status, and copies the pending descriptor into the running registers, which appear on the engine outputs.
- R7: `irq[2k]` = done enable AND done status of channel k. `irq[2k+1]` = error enable AND error status of channel k. Status bits written by software count.
- R8: An `eng_done[k]` pulse sets done status and clears run. An `eng_err[k]` pulse sets error status and clears run.
- R9: An access whose channel number (address bits above bit 11) is not below NUM_CH reads as zero and changes no state.
- R10: Offsets that are not mapped inside a valid channel read as zero and ignore writes.
- R11: The byte-count and address registers (pending at 0x008/0x010/0x018, running at 0x108/0x110/0x118) accept 64-bit accesses at that offset. A 32-bit access at the offset reaches the low half, and a 32-bit access at offset+4 reaches the high half.
- R12: After reset every register reads zero, and every interrupt, start pulse and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| bus_addr | input | ADDR_W | Byte address: channel above bit 11, offset below |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| eng_start | output | NUM_CH | One-cycle launch pulse per channel |
| eng_cfg | output | NUM_CH*32 | Running config per channel |
| eng_bytes | output | NUM_CH*64 | Running byte count per channel |
| eng_dst | output | NUM_CH*64 | Running destination per channel |
| eng_src | output | NUM_CH*64 | Running source per channel |
| eng_done | input | NUM_CH | Engine completion pulse per channel |
| eng_err | input | NUM_CH | Engine fault pulse per channel |
| irq | output | 2*NUM_CH | Completion (even) and fault (odd) interrupts |

## Verification
The assertions check on every cycle the ownership rules. Run never stays set without claim. A write to an unclaimed channel never launches. Claim is held across a write during a run. Newly gained claim always shows the defaults. They also check that the running copy moves only on a launch and that it matches the pending copy then. Further properties cover engine completion clearing run and unknown channels reading as zero. Only the bench scenarios can show the register decode itself: the bit layout read back, the split of 64-bit registers into halves, ignored writes to unmapped and read-only offsets, and the exact cycle of each start pulse and interrupt edge against the reference model.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int OFF_W  = 12;
    localparam int WORD_W = 64;
    localparam int CFG_W  = 32;
    localparam int SZ_W   = 4;
    localparam logic [SZ_W-1:0] SZ_DEFAULT = 4'd6;
    localparam int RD_SZ_LSB = 28;
    localparam int WR_SZ_LSB = 24;
    localparam logic [CFG_W-1:0] CFG_DEFAULT =
        (CFG_W'(SZ_DEFAULT) << RD_SZ_LSB) | (CFG_W'(SZ_DEFAULT) << WR_SZ_LSB);

    // control bit positions
    localparam int B_CLAIM   = 0;
    localparam int B_RUN     = 1;
    localparam int B_DONE_IE = 14;
    localparam int B_ERR_IE  = 15;
    localparam int B_DONE    = 30;
    localparam int B_ERR     = 31;

    typedef struct packed {
        logic err;
        logic done;
        logic err_ie;
        logic done_ie;
        logic run;
        logic claim;
    } ctrl_t;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [WORD_W-1:0] bytes;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] src;
    } desc_t;

    typedef enum logic [3:0] {
        F_NONE, F_CTRL, F_NCFG, F_NBYTES, F_NDST, F_NSRC,
        F_XCFG, F_XBYTES, F_XDST, F_XSRC
    } field_e;

    typedef struct packed {
        field_e f;
        logic   hi;
    } dec_t;

    function automatic dec_t decode(input logic [OFF_W-1:0] off);
        dec_t d;
        d.f  = F_NONE;
        d.hi = 1'b0;
        case (off)
            12'h000: d.f = F_CTRL;
            12'h004: d.f = F_NCFG;
            12'h008: d.f = F_NBYTES;
            12'h00C: begin d.f = F_NBYTES; d.hi = 1'b1; end
            12'h010: d.f = F_NDST;
            12'h014: begin d.f = F_NDST; d.hi = 1'b1; end
            12'h018: d.f = F_NSRC;
            12'h01C: begin d.f = F_NSRC; d.hi = 1'b1; end
            12'h104: d.f = F_XCFG;
            12'h108: d.f = F_XBYTES;
            12'h10C: begin d.f = F_XBYTES; d.hi = 1'b1; end
            12'h110: d.f = F_XDST;
            12'h114: begin d.f = F_XDST; d.hi = 1'b1; end
            12'h118: d.f = F_XSRC;
            12'h11C: begin d.f = F_XSRC; d.hi = 1'b1; end
            default: d.f = F_NONE;
        endcase
        return d;
    endfunction

    function automatic logic [CFG_W-1:0] ctrl_word(input ctrl_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[B_CLAIM]   = c.claim;
        w[B_RUN]     = c.run;
        w[B_DONE_IE] = c.done_ie;
        w[B_ERR_IE]  = c.err_ie;
        w[B_DONE]    = c.done;
        w[B_ERR]     = c.err;
        return w;
    endfunction

    function automatic ctrl_t ctrl_from(input logic [CFG_W-1:0] w);
        ctrl_t c;
        c.claim   = w[B_CLAIM];
        c.run     = w[B_RUN];
        c.done_ie = w[B_DONE_IE];
        c.err_ie  = w[B_ERR_IE];
        c.done    = w[B_DONE];
        c.err     = w[B_ERR];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] rd_part(input logic [WORD_W-1:0] r,
                                                  input logic hi, input logic wide);
        if (hi)
            return {32'h0, r[63:32]};
        else if (wide)
            return r;
        else
            return {32'h0, r[31:0]};
    endfunction

    function automatic logic [WORD_W-1:0] wr_part(input logic [WORD_W-1:0] old,
                                                  input logic [WORD_W-1:0] w,
                                                  input logic hi, input logic wide);
        if (hi)
            return {w[31:0], old[31:0]};
        else if (wide)
            return w;
        else
            return {old[63:32], w[31:0]};
    endfunction

endpackage

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_i,
    input  logic [OFF_W-1:0]      off_i,
    input  logic                  wide_i,
    input  logic [WORD_W-1:0]     wdata_i,
    input  logic                  eng_done_i,
    input  logic                  eng_err_i,
    output logic                  start_o,
    output desc_t                 exec_o,
    output logic [WORD_W-1:0]     rd_val_o,
    output logic                  irq_done_o,
    output logic                  irq_err_o
);

    ctrl_t ctrl_q, ctrl_d;
    desc_t nxt_q, nxt_d;
    desc_t exe_q, exe_d;
    logic  start_q, start_d;
    dec_t  dec;
    ctrl_t v;
    logic  permit;
    logic  wr_ctrl;

    assign dec     = decode(off_i);
    assign v       = ctrl_from(wdata_i[CFG_W-1:0]);
    assign wr_ctrl = wr_en_i && (dec.f == F_CTRL);

    always_comb begin
        ctrl_d  = ctrl_q;
        nxt_d   = nxt_q;
        exe_d   = exe_q;
        start_d = 1'b0;
        permit  = 1'b0;
        if (wr_en_i) begin
            case (dec.f)
                F_CTRL: begin
                    if (!ctrl_q.claim && v.claim) begin
                        nxt_d.cfg   = CFG_DEFAULT;
                        nxt_d.bytes = '0;
                        nxt_d.dst   = '0;
                        nxt_d.src   = '0;
                    end
                    permit       = ctrl_q.claim && (ctrl_q.run || v.claim);
                    ctrl_d       = v;
                    ctrl_d.claim = v.claim | ctrl_q.run;
                    if (!permit) begin
                        ctrl_d.run = 1'b0;
                    end else if (!ctrl_q.run && v.run) begin
                        start_d     = 1'b1;
                        ctrl_d.done = 1'b0;
                        ctrl_d.err  = 1'b0;
                        exe_d       = nxt_q;
                    end
                end
                F_NCFG:   nxt_d.cfg   = wdata_i[CFG_W-1:0];
                F_NBYTES: nxt_d.bytes = wr_part(nxt_q.bytes, wdata_i, dec.hi, wide_i);
                F_NDST:   nxt_d.dst   = wr_part(nxt_q.dst, wdata_i, dec.hi, wide_i);
                F_NSRC:   nxt_d.src   = wr_part(nxt_q.src, wdata_i, dec.hi, wide_i);
                default: ;
            endcase
        end
        if (eng_done_i) begin
            ctrl_d.done = 1'b1;
            ctrl_d.run  = 1'b0;
        end
        if (eng_err_i) begin
            ctrl_d.err = 1'b1;
            ctrl_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            nxt_q   <= '0;
            exe_q   <= '0;
            start_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            nxt_q   <= nxt_d;
            exe_q   <= exe_d;
            start_q <= start_d;
        end
    end

    always_comb begin
        case (dec.f)
            F_CTRL:   rd_val_o = {32'h0, ctrl_word(ctrl_q)};
            F_NCFG:   rd_val_o = {32'h0, nxt_q.cfg};
            F_NBYTES: rd_val_o = rd_part(nxt_q.bytes, dec.hi, wide_i);
            F_NDST:   rd_val_o = rd_part(nxt_q.dst, dec.hi, wide_i);
            F_NSRC:   rd_val_o = rd_part(nxt_q.src, dec.hi, wide_i);
            F_XCFG:   rd_val_o = {32'h0, exe_q.cfg};
            F_XBYTES: rd_val_o = rd_part(exe_q.bytes, dec.hi, wide_i);
            F_XDST:   rd_val_o = rd_part(exe_q.dst, dec.hi, wide_i);
            F_XSRC:   rd_val_o = rd_part(exe_q.src, dec.hi, wide_i);
            default:  rd_val_o = '0;
        endcase
    end

    assign start_o    = start_q;
    assign exec_o     = exe_q;
    assign irq_done_o = ctrl_q.done_ie & ctrl_q.done;
    assign irq_err_o  = ctrl_q.err_ie & ctrl_q.err;

    // R5: run is never held without ownership
    a_r5_run_needs_claim: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.run |-> ctrl_q.claim);

    // R5: a control write to an unowned channel never launches
    a_r5_no_start_unclaimed: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !ctrl_q.claim) |=> (!ctrl_q.run && !start_q));

    // R4: ownership survives a control write during a run
    a_r4_claim_held: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && ctrl_q.run) |=> ctrl_q.claim);

    // R2: newly gained ownership shows the default pending descriptor
    a_r2_claim_defaults: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.claim) |-> (nxt_q.cfg == CFG_DEFAULT && nxt_q.bytes == '0
                                 && nxt_q.dst == '0 && nxt_q.src == '0));

    // R3: the running copy moves only on a launch
    a_r3_exec_stable: assert property (@(posedge clk) disable iff (rst)
        !start_q |-> $stable(exe_q));

    // R6: launch state is consistent in the pulse cycle
    a_r6_start_state: assert property (@(posedge clk) disable iff (rst)
        (start_q && !$past(eng_done_i || eng_err_i)) |->
            (ctrl_q.run && !ctrl_q.done && !ctrl_q.err && exe_q == nxt_q));

    // R8: engine completion stops the run and flags done
    a_r8_done_stops: assert property (@(posedge clk) disable iff (rst)
        eng_done_i |=> (ctrl_q.done && !ctrl_q.run));

endmodule

// File: rtl/dmareg_rdsel.sv
module dmareg_rdsel
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rd_req_i,
    input  logic [CH_W-1:0]                ch_i,
    input  logic                           ch_ok_i,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  vals_i,
    output logic [WORD_W-1:0]              rdata_o
);

    logic [WORD_W-1:0] sel;
    logic [WORD_W-1:0] rdata_q;

    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (ch_ok_i && ch_i == CH_W'(k))
                sel = vals_i[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_req_i)
            rdata_q <= sel;
    end

    assign rdata_o = rdata_q;

    // R9: a read of a channel that does not exist returns zero
    a_r9_bad_ch_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req_i && !ch_ok_i) |=> (rdata_o == '0));

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic                     bus_wide,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [63:0]              bus_wdata,
    output logic [63:0]              bus_rdata,
    output logic [NUM_CH-1:0]        eng_start,
    output logic [NUM_CH*32-1:0]     eng_cfg,
    output logic [NUM_CH*64-1:0]     eng_bytes,
    output logic [NUM_CH*64-1:0]     eng_dst,
    output logic [NUM_CH*64-1:0]     eng_src,
    input  logic [NUM_CH-1:0]        eng_done,
    input  logic [NUM_CH-1:0]        eng_err,
    output logic [2*NUM_CH-1:0]      irq
);

    localparam int CH_W = ADDR_W - OFF_W;
    localparam logic [31:0] NUM_CH_U = NUM_CH;

    logic [CH_W-1:0]                ch_idx;
    logic [OFF_W-1:0]               off;
    logic                           ch_ok;
    logic [NUM_CH-1:0][WORD_W-1:0]  rd_vals;

    assign ch_idx = bus_addr[ADDR_W-1:OFF_W];
    assign off    = bus_addr[OFF_W-1:0];
    assign ch_ok  = 32'(ch_idx) < NUM_CH_U;

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            desc_t ex;
            logic  wr_k;
            assign wr_k = bus_valid && bus_write && ch_ok && (ch_idx == CH_W'(k));

            dmareg_chan i_chan (
                .clk        (clk),
                .rst        (rst),
                .wr_en_i    (wr_k),
                .off_i      (off),
                .wide_i     (bus_wide),
                .wdata_i    (bus_wdata),
                .eng_done_i (eng_done[k]),
                .eng_err_i  (eng_err[k]),
                .start_o    (eng_start[k]),
                .exec_o     (ex),
                .rd_val_o   (rd_vals[k]),
                .irq_done_o (irq[2*k]),
                .irq_err_o  (irq[2*k+1])
            );

            assign eng_cfg[k*32 +: 32]   = ex.cfg;
            assign eng_bytes[k*64 +: 64] = ex.bytes;
            assign eng_dst[k*64 +: 64]   = ex.dst;
            assign eng_src[k*64 +: 64]   = ex.src;
        end
    endgenerate

    dmareg_rdsel #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) i_rdsel (
        .clk      (clk),
        .rst      (rst),
        .rd_req_i (bus_valid && !bus_write),
        .ch_i     (ch_idx),
        .ch_ok_i  (ch_ok),
        .vals_i   (rd_vals),
        .rdata_o  (bus_rdata)
    );

endmodule

// File: tb/test_dmareg_top.sv
module test_dmareg_top;

    localparam int NCH = 4;
    localparam int AW  = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_valid = 1'b0;
    logic               bus_write = 1'b0;
    logic               bus_wide = 1'b0;
    logic [AW-1:0]      bus_addr = '0;
    logic [63:0]        bus_wdata = '0;
    logic [63:0]        bus_rdata;
    logic [NCH-1:0]     eng_start;
    logic [NCH*32-1:0]  eng_cfg;
    logic [NCH*64-1:0]  eng_bytes;
    logic [NCH*64-1:0]  eng_dst;
    logic [NCH*64-1:0]  eng_src;
    logic [NCH-1:0]     eng_done = '0;
    logic [NCH-1:0]     eng_err = '0;
    logic [2*NCH-1:0]   irq;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dmareg_top #(.NUM_CH(NCH), .ADDR_W(AW)) i_dmareg_top (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_cfg(eng_cfg),
        .eng_bytes(eng_bytes), .eng_dst(eng_dst), .eng_src(eng_src),
        .eng_done(eng_done), .eng_err(eng_err), .irq(irq)
    );

    // behavioural reference of control state, interrupts and start pulses
    bit m_claim[NCH], m_run[NCH], m_die[NCH], m_eie[NCH], m_done[NCH], m_err[NCH];
    bit m_start[NCH];

    always @(posedge clk) begin
        int ch;
        int off;
        bit wc, wr, okp;
        ch  = int'(bus_addr[15:12]);
        off = int'(bus_addr[11:0]);
        for (int k = 0; k < NCH; k++) m_start[k] = 0;
        if (rst) begin
            for (int k = 0; k < NCH; k++) begin
                m_claim[k] = 0; m_run[k] = 0; m_die[k] = 0;
                m_eie[k] = 0; m_done[k] = 0; m_err[k] = 0;
            end
        end else begin
            if (bus_valid && bus_write && ch < NCH && off == 0) begin
                wc  = bus_wdata[0];
                wr  = bus_wdata[1];
                okp = m_claim[ch] && (m_run[ch] || wc);
                if (okp && !m_run[ch] && wr) begin
                    m_start[ch] = 1;
                    m_done[ch]  = 0;
                    m_err[ch]   = 0;
                end else begin
                    m_done[ch] = bus_wdata[30];
                    m_err[ch]  = bus_wdata[31];
                end
                m_claim[ch] = wc || m_run[ch];
                m_run[ch]   = okp ? wr : 0;
                m_die[ch]   = bus_wdata[14];
                m_eie[ch]   = bus_wdata[15];
            end
            for (int k = 0; k < NCH; k++) begin
                if (eng_done[k]) begin m_done[k] = 1; m_run[k] = 0; end
                if (eng_err[k])  begin m_err[k] = 1;  m_run[k] = 0; end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < NCH; k++) begin
                tests++;
                if (irq[2*k] !== (m_die[k] & m_done[k]) ||
                    irq[2*k+1] !== (m_eie[k] & m_err[k])) begin
                    fails++;
                    $display("FAIL R7 ch%0d irq act=%b%b exp=%b%b", k, irq[2*k+1], irq[2*k],
                             m_eie[k] & m_err[k], m_die[k] & m_done[k]);
                end
                tests++;
                if (eng_start[k] !== m_start[k]) begin
                    fails++;
                    $display("FAIL R6 ch%0d start act=%b exp=%b", k, eng_start[k], m_start[k]);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int off, input logic [63:0] d, input bit wide);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_wide = wide;
        bus_addr  = AW'(ch * 4096 + off); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_wide = 0;
    endtask

    task automatic rd(input string tag, input int ch, input int off, input bit wide,
                      input logic [63:0] exp);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_wide = wide;
        bus_addr  = AW'(ch * 4096 + off);
        @(negedge clk);
        bus_valid = 0; bus_wide = 0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input int ch, input bit is_err);
        @(negedge clk);
        if (is_err) eng_err[ch] = 1; else eng_done[ch] = 1;
        @(negedge clk);
        eng_err = '0; eng_done = '0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        check("R12 rdata", bus_rdata, 64'h0);
        check("R12 irq", {56'h0, irq}, 64'h0);
        check("R12 start", {60'h0, eng_start}, 64'h0);
        rd("R12 ctrl", 0, 12'h000, 0, 64'h0);
        rd("R12 exec cfg", 0, 12'h104, 0, 64'h0);

        // R2 claim clears pending registers; R5 run forced low when unclaimed
        wr(0, 12'h008, 64'h1234, 1);
        rd("R2 bytes before claim", 0, 12'h008, 1, 64'h1234);
        wr(0, 12'h000, 64'h3, 0);
        rd("R5 run forced 0 unclaimed", 0, 12'h000, 0, 64'h1);
        rd("R2 bytes cleared", 0, 12'h008, 1, 64'h0);
        rd("R2 cfg default", 0, 12'h004, 0, 64'h6600_0000);

        // R11 wide and half accesses
        wr(0, 12'h010, 64'h1111_2222_3333_4444, 1);
        rd("R11 dst wide", 0, 12'h010, 1, 64'h1111_2222_3333_4444);
        rd("R11 dst high half", 0, 12'h014, 0, 64'h1111_2222);
        rd("R11 dst low half", 0, 12'h010, 0, 64'h3333_4444);
        wr(0, 12'h018, 64'hAAAA_0000, 0);
        wr(0, 12'h01C, 64'h5, 0);
        rd("R11 src halves", 0, 12'h018, 1, 64'h0000_0005_AAAA_0000);
        wr(0, 12'h008, 64'h40, 1);
        wr(0, 12'h004, 64'h6600_0004, 0);

        // R3 running copy ignores writes
        wr(0, 12'h108, 64'hDEAD, 1);
        rd("R3 exec bytes ignored", 0, 12'h108, 1, 64'h0);

        // R6 launch
        wr(0, 12'h000, 64'hC003, 0);
        check("R6 start pulse", {63'h0, eng_start[0]}, 64'h1);
        @(negedge clk);
        check("R6 start one cycle", {63'h0, eng_start[0]}, 64'h0);
        check("R6 engine bytes", eng_bytes[63:0], 64'h40);
        check("R6 engine dst", eng_dst[63:0], 64'h1111_2222_3333_4444);
        rd("R3 exec cfg loaded", 0, 12'h104, 0, 64'h6600_0004);
        rd("R11 exec src high", 0, 12'h11C, 0, 64'h5);
        wr(0, 12'h118, 64'h0, 1);
        rd("R3 exec src ignored", 0, 12'h118, 1, 64'h0000_0005_AAAA_0000);
        rd("R1 ctrl running", 0, 12'h000, 0, 64'hC003);

        // R8 engine completion, R7 interrupt
        pulse(0, 0);
        rd("R8 done sets status", 0, 12'h000, 0, 64'h4000_C001);
        check("R7 done irq", {63'h0, irq[0]}, 64'h1);

        // R4 claim held while running
        wr(0, 12'h000, 64'hC003, 0);
        rd("R6 done cleared on start", 0, 12'h000, 0, 64'hC003);
        wr(0, 12'h000, 64'hC002, 0);
        rd("R4 claim kept", 0, 12'h000, 0, 64'hC003);
        pulse(0, 1);
        rd("R8 err sets status", 0, 12'h000, 0, 64'h8000_C001);
        check("R7 err irq", {63'h0, irq[1]}, 64'h1);

        // R5 release with run low blocks start
        wr(0, 12'h000, 64'h2, 0);
        rd("R5 release blocks run", 0, 12'h000, 0, 64'h0);

        // R7 software-written status on channel 1
        wr(1, 12'h000, 64'h1, 0);
        wr(1, 12'h000, 64'h4000_4001, 0);
        check("R7 sw done irq", {63'h0, irq[2]}, 64'h1);

        // R9 nonexistent channel
        wr(5, 12'h000, 64'hFFFF_FFFF, 0);
        wr(5, 12'h008, 64'h77, 1);
        rd("R9 bad ch ctrl", 5, 12'h000, 0, 64'h0);
        rd("R9 bad ch bytes", 5, 12'h008, 1, 64'h0);
        rd("R9 ch1 untouched", 1, 12'h000, 0, 64'h4000_4001);

        // R10 unmapped offsets
        wr(1, 12'h020, 64'hFFFF, 0);
        rd("R10 unmapped read", 1, 12'h020, 0, 64'h0);
        rd("R10 unmapped high", 1, 12'h0FC, 0, 64'h0);
        rd("R10 ch1 bytes untouched", 1, 12'h008, 1, 64'h0);

        // R1 bit layout
        wr(2, 12'h000, 64'h1, 0);
        wr(2, 12'h000, 64'hFFFF_FFFD, 0);
        rd("R1 layout", 2, 12'h000, 0, 64'hC000_C001);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule